// File: doc/BRIEF.md
# Colour Subcarrier and Burst Generator

This block synthesises the colour subcarrier for a digital NTSC/PAL video encoder. A phase accumulator running on the 27 MHz encoder clock advances by a per-standard step each cycle. Its top bits address a quarter-wave sine table, which yields signed sine and cosine samples for the downstream quadrature modulator. Every line the block opens a colour-burst window a fixed number of clocks after horizontal sync ends. The window stays open for exactly the burst length of the selected standard, counted in whole subcarrier periods (accumulator wraps).

In the PAL modes a line-alternating switch tells the modulator to invert V. The block reports the burst phase that goes with the switch state. The sync generator supplies the pixel, line and field counts and a per-line suppression flag for vertical-interval lines. At the start of each colour sequence (four fields for NTSC, eight for PAL) the accumulator is reloaded. This makes the subcarrier-to-sync phase repeatable.

Top module: `chroma_carrier_gen`

## Requirements
- R1: While `rst_n` is low, `sin_o`, `cos_o`, `burst_en_o` and `pal_sw_o` are 0. With `mode_i` = 00 (sleep), `burst_phase_o` is also 0.
- R2: `mode_i` encodes 11 = NTSC, 10 = PAL, 01 = PAL-60 and 00 = sleep. On each clock edge outside sleep, the 32-bit accumulator advances by round(f·2^32 / 27e6). Here f is 3 579 545 Hz in NTSC and 4 433 619 Hz in both PAL modes.
- R3: One edge after the accumulator holds phase P, `sin_o` equals round(255·sin(2π(T+0.5)/256)), where T = P[31:24]. `cos_o` is the same expression with T+64 (mod 256). Both are 9-bit two's complement.
- R4: On an edge where `pix_cnt_i` = 0, `line_cnt_i` = 0 and the field index starts a colour sequence, the accumulator reloads to 0 instead of advancing. The field index starts a sequence when `field_idx_i[1:0]` = 0 in NTSC and when `field_idx_i` = 0 in the PAL modes.
- R5: On an edge where `pix_cnt_i` = 72 (64 sync clocks plus an 8-clock gap), `vblank_i` is low and the mode is not sleep, `burst_en_o` rises.
- R6: `burst_en_o` falls on the edge of the 9th accumulator wrap after opening in NTSC, and of the 10th wrap in the PAL modes.
- R7: In the PAL modes, `pal_sw_o` toggles on each edge with `pix_cnt_i` = 0 and holds within the line. It is cleared on a sequence-start edge. In NTSC and sleep it is 0.
- R8: `burst_phase_o` gives the burst angle in units of 360/256 degrees. It is 128 (180°) in NTSC, 96 (135°) in PAL with the switch at 0, and 160 (225°) with the switch at 1.
- R9: In sleep, the accumulator holds its phase, `sin_o` and `cos_o` become 0 after one edge, the burst window closes, and `burst_phase_o` is 0.
- R10: A line whose opening edge sees `vblank_i` high gets no burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz encoder clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Standard select: 11 NTSC, 10 PAL, 01 PAL-60, 00 sleep |
| pix_cnt_i | input | 11 | Clock count within the line, 0 at line start |
| line_cnt_i | input | 10 | Line count within the field |
| field_idx_i | input | 3 | Field index within the colour sequence |
| vblank_i | input | 1 | High on lines whose burst is suppressed |
| sin_o | output | 9 | Signed subcarrier sine sample |
| cos_o | output | 9 | Signed subcarrier cosine sample |
| burst_en_o | output | 1 | Burst gating window |
| burst_phase_o | output | 8 | Burst angle code |
| pal_sw_o | output | 1 | Line-alternating V inversion flag |

## Verification
Inputs presented before an edge change the accumulator, `burst_en_o` and `pal_sw_o` at that edge. The sine and cosine samples follow one edge later, because they are registered from the accumulator. `burst_phase_o` follows the present mode and switch with no clock. The bench drives inputs just after each falling edge. A cycle-exact arithmetic model, advanced on the rising edge from the same inputs, supplies the expected values, and the outputs are compared at the next falling edge. The reload check therefore waits two falling edges after presenting the sequence-start inputs.

// File: rtl/cs_pkg.sv
`timescale 1ns/1ps
package cs_pkg;

   typedef enum logic [1:0] {
      MODE_SLEEP = 2'b00,
      MODE_PAL60 = 2'b01,
      MODE_PAL   = 2'b10,
      MODE_NTSC  = 2'b11
   } cs_mode_e;

   localparam logic [7:0] PH_CODE_NTSC  = 8'd128;
   localparam logic [7:0] PH_CODE_PAL_P = 8'd96;
   localparam logic [7:0] PH_CODE_PAL_N = 8'd160;

   // rounded accumulator step for a subcarrier frequency at a given clock
   function automatic longint unsigned phase_step(input longint unsigned f_hz,
                                                  input longint unsigned clk_hz,
                                                  input int unsigned     acc_w);
      return ((f_hz << acc_w) + (clk_hz >> 1)) / clk_hz;
   endfunction

endpackage

// File: rtl/cs_phase_acc.sv
`timescale 1ns/1ps
module cs_phase_acc #(
   parameter int ACC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_i,
   input  logic             load_i,
   input  logic [ACC_W-1:0] inc_i,
   input  logic [ACC_W-1:0] load_val_i,
   output logic [ACC_W-1:0] acc_o,
   output logic             wrap_o
);

   logic [ACC_W:0] sum;

   assign sum    = {1'b0, acc_o} + {1'b0, inc_i};
   assign wrap_o = step_i && !load_i && sum[ACC_W];

   always_ff @(posedge clk) begin
      if (!rst_n)      acc_o <= '0;
      else if (load_i) acc_o <= load_val_i;
      else if (step_i) acc_o <= sum[ACC_W-1:0];
   end

endmodule

// File: rtl/cs_sine_lut.sv
`timescale 1ns/1ps
module cs_sine_lut #(
   parameter int ACC_W  = 32,
   parameter int QBITS  = 6,
   parameter int SAMP_W = 9
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     en_i,
   input  logic [ACC_W-1:0]         phase_i,
   output logic signed [SAMP_W-1:0] sin_o,
   output logic signed [SAMP_W-1:0] cos_o
);

   localparam int IDX_W = QBITS + 2;
   localparam int QN    = 1 << QBITS;
   localparam int AMP   = (1 << (SAMP_W - 1)) - 1;

   logic signed [SAMP_W-1:0] qtab [QN];

   // quarter wave sampled at half-step offsets so both mirrors line up
   for (genvar k = 0; k < QN; k++) begin : g_tab
      localparam real ANG = 3.14159265358979 * (2.0 * k + 1.0) / (4.0 * QN);
      localparam int  VAL = int'(AMP * $sin(ANG));
      assign qtab[k] = SAMP_W'(VAL);
   end

   function automatic logic signed [SAMP_W-1:0] fold(input logic [IDX_W-1:0] ix);
      logic [QBITS-1:0]         fine;
      logic signed [SAMP_W-1:0] mag;
      fine = ix[IDX_W-2] ? ~ix[QBITS-1:0] : ix[QBITS-1:0];
      mag  = qtab[fine];
      return ix[IDX_W-1] ? -mag : mag;
   endfunction

   logic [IDX_W-1:0] s_idx, c_idx;

   assign s_idx = phase_i[ACC_W-1 -: IDX_W];
   assign c_idx = s_idx + IDX_W'(QN);

   always_ff @(posedge clk) begin
      if (!rst_n || !en_i) begin
         sin_o <= '0;
         cos_o <= '0;
      end else begin
         sin_o <= fold(s_idx);
         cos_o <= fold(c_idx);
      end
   end

endmodule

// File: rtl/cs_burst_gate.sv
`timescale 1ns/1ps
module cs_burst_gate
   import cs_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sleep_i,
   input  logic             pal_i,
   input  logic             seq_i,
   input  logic             line_start_i,
   input  logic             open_i,
   input  logic             vblank_i,
   input  logic             wrap_i,
   input  logic [CNT_W-1:0] last_i,
   output logic             burst_en_o,
   output logic             pal_sw_o,
   output logic [7:0]       phase_o
);

   logic [CNT_W-1:0] wcnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         burst_en_o <= 1'b0;
         wcnt       <= '0;
      end else if (sleep_i) begin
         burst_en_o <= 1'b0;
      end else if (open_i && !vblank_i) begin
         burst_en_o <= 1'b1;
         wcnt       <= '0;
      end else if (burst_en_o && wrap_i) begin
         if (wcnt == last_i) burst_en_o <= 1'b0;
         else                wcnt       <= wcnt + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !pal_i || seq_i) pal_sw_o <= 1'b0;
      else if (line_start_i)         pal_sw_o <= ~pal_sw_o;
   end

   always_comb begin
      if (sleep_i)     phase_o = 8'd0;
      else if (!pal_i) phase_o = PH_CODE_NTSC;
      else             phase_o = pal_sw_o ? PH_CODE_PAL_N : PH_CODE_PAL_P;
   end

endmodule

// File: rtl/chroma_carrier_gen.sv
`timescale 1ns/1ps
module chroma_carrier_gen
   import cs_pkg::*;
#(
   parameter int          ACC_W       = 32,
   parameter int          QBITS       = 6,
   parameter int          SAMP_W      = 9,
   parameter int          PIX_W       = 11,
   parameter int          LINE_W      = 10,
   parameter int          HSYNC_CLKS  = 64,
   parameter int          BURST_GAP   = 8,
   parameter int          CYC_NTSC    = 9,
   parameter int          CYC_PAL     = 10,
   parameter longint      CLK_HZ      = 27000000,
   parameter longint      FSC_NTSC_HZ = 3579545,
   parameter longint      FSC_PAL_HZ  = 4433619,
   parameter logic [31:0] SEQ_PHASE   = 32'd0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [1:0]               mode_i,
   input  logic [PIX_W-1:0]         pix_cnt_i,
   input  logic [LINE_W-1:0]        line_cnt_i,
   input  logic [2:0]               field_idx_i,
   input  logic                     vblank_i,
   output logic signed [SAMP_W-1:0] sin_o,
   output logic signed [SAMP_W-1:0] cos_o,
   output logic                     burst_en_o,
   output logic [7:0]               burst_phase_o,
   output logic                     pal_sw_o
);

   localparam int         BURST_POS = HSYNC_CLKS + BURST_GAP;
   localparam int         CYC_MAX   = (CYC_NTSC > CYC_PAL) ? CYC_NTSC : CYC_PAL;
   localparam int         CNT_W     = $clog2(CYC_MAX + 1);
   localparam logic [ACC_W-1:0] INC_NTSC =
      ACC_W'(phase_step(longint'(FSC_NTSC_HZ), longint'(CLK_HZ), ACC_W));
   localparam logic [ACC_W-1:0] INC_PAL  =
      ACC_W'(phase_step(longint'(FSC_PAL_HZ), longint'(CLK_HZ), ACC_W));

   if (ACC_W < QBITS + 4 || ACC_W > 32) begin : g_bad_acc
      $error("ACC_W out of range");
   end
   if (QBITS < 2 || QBITS > 8) begin : g_bad_q
      $error("QBITS out of range");
   end
   if (SAMP_W < 4 || SAMP_W > 16) begin : g_bad_samp
      $error("SAMP_W out of range");
   end
   if (BURST_POS >= (1 << PIX_W)) begin : g_bad_pos
      $error("burst position does not fit the pixel count");
   end
   if (CYC_NTSC < 1 || CYC_PAL < 1) begin : g_bad_cyc
      $error("burst length must be positive");
   end

   cs_mode_e   mode;
   logic       sleep, pal, seq_start, wrap;
   logic [ACC_W-1:0] inc, acc;
   logic [CNT_W-1:0] last_wrap;

   assign mode      = cs_mode_e'(mode_i);
   assign sleep     = (mode == MODE_SLEEP);
   assign pal       = (mode == MODE_PAL) || (mode == MODE_PAL60);
   assign inc       = pal ? INC_PAL : INC_NTSC;
   assign last_wrap = pal ? CNT_W'(CYC_PAL - 1) : CNT_W'(CYC_NTSC - 1);
   assign seq_start = !sleep && (pix_cnt_i == '0) && (line_cnt_i == '0) &&
                      (pal ? (field_idx_i == 3'd0) : (field_idx_i[1:0] == 2'd0));

   cs_phase_acc #(.ACC_W(ACC_W)) u_acc (
      .clk        (clk),
      .rst_n      (rst_n),
      .step_i     (!sleep),
      .load_i     (seq_start),
      .inc_i      (inc),
      .load_val_i (ACC_W'(SEQ_PHASE)),
      .acc_o      (acc),
      .wrap_o     (wrap)
   );

   cs_sine_lut #(.ACC_W(ACC_W), .QBITS(QBITS), .SAMP_W(SAMP_W)) u_lut (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_i    (!sleep),
      .phase_i (acc),
      .sin_o   (sin_o),
      .cos_o   (cos_o)
   );

   cs_burst_gate #(.CNT_W(CNT_W)) u_gate (
      .clk          (clk),
      .rst_n        (rst_n),
      .sleep_i      (sleep),
      .pal_i        (pal),
      .seq_i        (seq_start),
      .line_start_i (pix_cnt_i == '0),
      .open_i       (pix_cnt_i == PIX_W'(BURST_POS)),
      .vblank_i     (vblank_i),
      .wrap_i       (wrap),
      .last_i       (last_wrap),
      .burst_en_o   (burst_en_o),
      .pal_sw_o     (pal_sw_o),
      .phase_o      (burst_phase_o)
   );

endmodule

// File: rtl/chroma_carrier_gen_chk.sv
`timescale 1ns/1ps
module chroma_carrier_gen_chk #(
   parameter int PIX_W     = 11,
   parameter int SAMP_W    = 9,
   parameter int BURST_POS = 72
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [1:0]               mode_i,
   input logic [PIX_W-1:0]         pix_cnt_i,
   input logic                     vblank_i,
   input logic signed [SAMP_W-1:0] sin_o,
   input logic signed [SAMP_W-1:0] cos_o,
   input logic                     burst_en_o,
   input logic                     pal_sw_o
);

   AST_SLEEP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 2'b00) |=> (sin_o == '0 && cos_o == '0 && !burst_en_o)); // R9

   AST_NTSC_NO_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 2'b11) |=> !pal_sw_o); // R7

   AST_SWITCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_i == 2'b10 || mode_i == 2'b01) && pix_cnt_i != '0) |=> $stable(pal_sw_o)); // R7

   AST_BURST_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_cnt_i == PIX_W'(BURST_POS) && !vblank_i && mode_i != 2'b00) |=> burst_en_o); // R5

   AST_VBLANK_NO_BURST: assert property (@(posedge clk) disable iff (!rst_n)
      (vblank_i && !burst_en_o) |=> !burst_en_o); // R10

endmodule

bind chroma_carrier_gen chroma_carrier_gen_chk #(
   .PIX_W     (PIX_W),
   .SAMP_W    (SAMP_W),
   .BURST_POS (BURST_POS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mode_i     (mode_i),
   .pix_cnt_i  (pix_cnt_i),
   .vblank_i   (vblank_i),
   .sin_o      (sin_o),
   .cos_o      (cos_o),
   .burst_en_o (burst_en_o),
   .pal_sw_o   (pal_sw_o)
);

// File: tb/chroma_carrier_gen_bench.sv
`timescale 1ns/1ps
module chroma_carrier_gen_bench;

   localparam int     B_LINE_LEN = 160;
   localparam int     B_LINES    = 4;
   localparam int     B_POS      = 72;
   localparam int     B_QN       = 64;
   localparam int     B_AMP      = 255;
   localparam real    B_PI       = 3.14159265358979;
   localparam longint unsigned B_INC_N = ((64'd3579545 << 32) + 64'd13500000) / 64'd27000000;
   localparam longint unsigned B_INC_P = ((64'd4433619 << 32) + 64'd13500000) / 64'd27000000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [1:0]        mode_i = 2'b00;
   logic [10:0]       pix_cnt_i = '0;
   logic [9:0]        line_cnt_i = '0;
   logic [2:0]        field_idx_i = '0;
   logic              vblank_i = 1'b0;
   logic signed [8:0] sin_o, cos_o;
   logic              burst_en_o, pal_sw_o;
   logic [7:0]        burst_phase_o;

   int n_chk = 0, n_bad = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   chroma_carrier_gen u_chroma_carrier_gen (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .pix_cnt_i(pix_cnt_i),
      .line_cnt_i(line_cnt_i), .field_idx_i(field_idx_i), .vblank_i(vblank_i),
      .sin_o(sin_o), .cos_o(cos_o), .burst_en_o(burst_en_o),
      .burst_phase_o(burst_phase_o), .pal_sw_o(pal_sw_o)
   );

   function automatic int ref_wave(input logic [31:0] ph, input bit cos_sel);
      int top = int'(ph[31:24]);
      if (cos_sel) top = (top + B_QN) % (4 * B_QN);
      return int'(B_AMP * $sin(2.0 * B_PI * (top + 0.5) / (4.0 * B_QN)));
   endfunction

   // cycle model, advanced on the rising edge from the applied inputs
   logic [31:0] m_acc = '0;
   int  m_sin = 0, m_cos = 0, m_wc = 0;
   bit  m_burst = 0, m_sw = 0;

   always @(posedge clk) begin
      bit sleep, pal, seq, carry;
      logic [32:0] nx;
      sleep = (mode_i == 2'b00);
      pal   = (mode_i == 2'b10) || (mode_i == 2'b01);
      if (!rst_n) begin
         m_acc = '0; m_sin = 0; m_cos = 0; m_burst = 0; m_wc = 0; m_sw = 0;
      end else begin
         seq = !sleep && pix_cnt_i == 0 && line_cnt_i == 0 &&
               (pal ? field_idx_i == 0 : field_idx_i[1:0] == 0);
         m_sin = sleep ? 0 : ref_wave(m_acc, 0);
         m_cos = sleep ? 0 : ref_wave(m_acc, 1);
         nx = {1'b0, m_acc} + (pal ? 33'(B_INC_P) : 33'(B_INC_N));
         carry = 0;
         if (sleep) begin
         end else if (seq) m_acc = '0;
         else begin
            m_acc = nx[31:0];
            carry = nx[32];
         end
         if (sleep) m_burst = 0;
         else if (pix_cnt_i == B_POS && !vblank_i) begin m_burst = 1; m_wc = 0; end
         else if (m_burst && carry) begin
            if (m_wc == (pal ? 9 : 8)) m_burst = 0;
            else m_wc++;
         end
         if (!pal || seq) m_sw = 0;
         else if (pix_cnt_i == 0) m_sw = ~m_sw;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int exp_phase();
      if (mode_i == 2'b00) return 0;
      if (mode_i == 2'b11) return 128;
      return m_sw ? 160 : 96;
   endfunction

   int b_pix = 0, b_line = 0, b_fld = 0, pend = 0;

   task automatic compare_all();
      bit sl = (mode_i == 2'b00);
      chk(int'(sin_o) == m_sin, sl ? "R9 sin" : "R2 R3 sin", int'(sin_o), m_sin);
      chk(int'(cos_o) == m_cos, sl ? "R9 cos" : "R3 cos", int'(cos_o), m_cos);
      chk(burst_en_o == m_burst, "R5 R6 R10 burst window", int'(burst_en_o), int'(m_burst));
      chk(pal_sw_o == m_sw, "R7 pal switch", int'(pal_sw_o), int'(m_sw));
      chk(int'(burst_phase_o) == exp_phase(), "R8 burst phase", int'(burst_phase_o), exp_phase());
      if (pend == 1 && !sl) begin
         chk(int'(sin_o) == ref_wave(32'd0, 0), "R4 reload sin", int'(sin_o), ref_wave(32'd0, 0));
         chk(int'(cos_o) == ref_wave(32'd0, 1), "R4 reload cos", int'(cos_o), ref_wave(32'd0, 1));
      end
      if (pend > 0) pend--;
   endtask

   task automatic run_mode(input logic [1:0] m, input int cycles);
      for (int c = 0; c < cycles; c++) begin
         @(negedge clk);
         compare_all();
         mode_i      = m;
         pix_cnt_i   = 11'(b_pix);
         line_cnt_i  = 10'(b_line);
         field_idx_i = 3'(b_fld);
         vblank_i    = (b_line == 0) || (b_fld == 5 && b_line == 2);
         if (b_pix == 0 && b_line == 0 && m != 2'b00 &&
             ((m == 2'b11) ? (b_fld % 4 == 0) : (b_fld == 0)))
            pend = 2;
         b_pix++;
         if (b_pix == B_LINE_LEN) begin
            b_pix = 0;
            b_line++;
            if (b_line == B_LINES) begin b_line = 0; b_fld = (b_fld + 1) % 8; end
         end
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(sin_o == '0 && cos_o == '0, "R1 reset samples", int'(sin_o), 0);
      chk(!burst_en_o && !pal_sw_o, "R1 reset flags", int'({burst_en_o, pal_sw_o}), 0);
      chk(burst_phase_o == 8'd0, "R1 reset phase code", int'(burst_phase_o), 0);
      rst_n = 1'b1;
      run_mode(2'b11, 10240);
      run_mode(2'b00, 500);
      run_mode(2'b11, 1000);
      run_mode(2'b10, 10240);
      run_mode(2'b01, 5120);
      run_mode(2'b00, 300);
      run_mode(2'b10, 700);
      @(negedge clk);
      compare_all();
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(4 * 150000);
      if (!finished) begin
         finished = 1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule